// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

The block gathers a bank of level-sensitive interrupt inputs together with a set of software-raised interrupt bits, each of which can be masked per line. Every line carries its own level setting that steers it either to the normal interrupt output or to the fast interrupt output, and that gives it a priority. For each of the two outputs the controller searches the unmasked pending lines steered there and picks the most urgent one. It latches the line number and the priority of that line in an active register, and it raises the output.

The output stays raised, and the active register stays frozen, until software writes the matching agreement bit in the control register. After that write the search starts again. All state is reached over a small register bus that accepts one request per cycle and answers one cycle later. A protection flag can restrict every register to privileged requests. The protection register itself always needs a privileged request.

Top module: `prio_intc`

## Requirements
- R1: After reset every line is masked (mask reads 0xFFFFFFFF), software bits, level registers and the protection flag read zero, both active registers read zero, and `irq_o` and `fiq_o` are low.
- R2: The mask reads at offset 0x010 and ignores writes there. Writing a 1 to a bit at 0x014 clears that mask bit, and writing a 1 to a bit at 0x018 sets it. Bits written as 0 leave their mask bits unchanged.
- R3: Writing a 1 to a bit at 0x01C raises that software interrupt bit, and reading 0x01C returns the raised bits. Writing a 1 to a bit at 0x020 lowers that bit. Bits written as 0 have no effect.
- R4: A line is pending when its input or its software bit is high. It competes for an output only when its mask bit is 0.
- R5: The level register of line n sits at 0x100 + 4n. Bit 0 steers the line to the fast output (1) or the normal output (0), and bits 7:2 hold the priority. Every other bit is ignored on write and reads as 0.
- R6: Among the competing lines of one output, the lowest priority value wins. Between equal priorities, the lowest line number wins.
- R7: The active registers are at 0x008 (normal) and 0x00C (fast). Each has bit 31 = valid, bits 13:8 = priority and bits 4:0 = line. The output equals the valid bit. Once latched, both stay unchanged even if the source goes away or is masked.
- R8: Writing control register 0x000 with bit 0 set releases the normal output, and with bit 1 set releases the fast output. A released output latches the next winner on the following clock edge. An output with no latched winner latches one on the first edge at which a competing line exists.
- R9: The protection flag is bit 0 at 0x004, and this register needs a privileged request at all times. While the flag is set, a non-privileged request to any other register is refused. A refused request changes nothing, returns zero data and sets `rsp_err`.
- R10: Every request cycle is followed, one cycle later, by exactly one response cycle. Reads of unmapped offsets return zero with no error, and write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Always high; one request accepted per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Request is privileged |
| req_addr | input | 12 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Request refused by protection |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench forces ties by drawing priorities from a narrow range. A design that compared with less-or-equal would then hand the win to the highest tied line instead of the lowest. It drops and masks the source after a winner has latched, which catches a design that tracks live inputs instead of holding until the agreement write. It also releases one output while a second line is still pending, to show the next winner takes over. Non-privileged accesses with the flag set must leave the mask untouched and read zero; a design that only flagged the error but still wrote would fail the mask readback. Writes carrying zero bits to the set and clear aliases catch a design that copies the whole word instead of acting on the ones.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 6,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int LW = $clog2(NLINES);
  localparam logic [AW-1:0] A_CTRL = 12'h000;
  localparam logic [AW-1:0] A_PROT = 12'h004;
  localparam logic [AW-1:0] A_IACT = 12'h008;
  localparam logic [AW-1:0] A_FACT = 12'h00C;
  localparam logic [AW-1:0] A_MASK = 12'h010;
  localparam logic [AW-1:0] A_MCLR = 12'h014;
  localparam logic [AW-1:0] A_MSET = 12'h018;
  localparam logic [AW-1:0] A_SSET = 12'h01C;
  localparam logic [AW-1:0] A_SCLR = 12'h020;
  localparam logic [AW-1:0] A_LVL  = 12'h100;

  logic [NLINES-1:0] mask_q, swi_q, lvl_fiq;
  logic [PRIO_W-1:0] lvl_pri [NLINES];
  logic              prot_q;
  logic              irq_v, fiq_v;
  logic [LW-1:0]     irq_ln, fiq_ln;
  logic [PRIO_W-1:0] irq_pr, fiq_pr;

  assign req_ready = 1'b1;
  assign irq_o = irq_v;
  assign fiq_o = fiq_v;

  wire is_prot = req_addr == A_PROT;
  wire blocked = req_valid && (is_prot ? !req_priv : (prot_q && !req_priv));
  wire wr      = req_valid && req_write && !blocked;
  wire lvl_hit = (req_addr[AW-1:LW+2] == A_LVL[AW-1:LW+2]) && (req_addr[1:0] == 2'b00);
  wire [LW-1:0] lvl_idx = req_addr[LW+1:2];
  wire ack_irq = wr && (req_addr == A_CTRL) && req_wdata[0];
  wire ack_fiq = wr && (req_addr == A_CTRL) && req_wdata[1];

  wire [NLINES-1:0] enabled  = (irq_lines | swi_q) & ~mask_q;
  wire [NLINES-1:0] irq_cand = enabled & ~lvl_fiq;
  wire [NLINES-1:0] fiq_cand = enabled & lvl_fiq;

  logic              i_hit, f_hit;
  logic [LW-1:0]     i_line, f_line;
  logic [PRIO_W-1:0] i_pri, f_pri;

  always_comb begin
    i_hit = 1'b0; i_line = '0; i_pri = '1;
    f_hit = 1'b0; f_line = '0; f_pri = '1;
    for (int n = 0; n < NLINES; n++) begin
      if (irq_cand[n] && (!i_hit || lvl_pri[n] < i_pri)) begin
        i_hit = 1'b1; i_line = LW'(n); i_pri = lvl_pri[n];
      end
      if (fiq_cand[n] && (!f_hit || lvl_pri[n] < f_pri)) begin
        f_hit = 1'b1; f_line = LW'(n); f_pri = lvl_pri[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      swi_q   <= '0;
      lvl_fiq <= '0;
      prot_q  <= 1'b0;
      for (int n = 0; n < NLINES; n++) lvl_pri[n] <= '0;
    end else if (wr) begin
      case (req_addr)
        A_PROT: prot_q <= req_wdata[0];
        A_MCLR: mask_q <= mask_q & ~req_wdata[NLINES-1:0];
        A_MSET: mask_q <= mask_q | req_wdata[NLINES-1:0];
        A_SSET: swi_q  <= swi_q | req_wdata[NLINES-1:0];
        A_SCLR: swi_q  <= swi_q & ~req_wdata[NLINES-1:0];
        default: if (lvl_hit) begin
          lvl_fiq[lvl_idx] <= req_wdata[0];
          lvl_pri[lvl_idx] <= req_wdata[PRIO_W+1:2];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_v <= 1'b0; irq_ln <= '0; irq_pr <= '0;
    end else if (ack_irq) begin
      irq_v <= 1'b0; irq_ln <= '0; irq_pr <= '0;
    end else if (!irq_v && i_hit) begin
      irq_v <= 1'b1; irq_ln <= i_line; irq_pr <= i_pri;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_v <= 1'b0; fiq_ln <= '0; fiq_pr <= '0;
    end else if (ack_fiq) begin
      fiq_v <= 1'b0; fiq_ln <= '0; fiq_pr <= '0;
    end else if (!fiq_v && f_hit) begin
      fiq_v <= 1'b1; fiq_ln <= f_line; fiq_pr <= f_pri;
    end
  end

  logic [31:0] rd;
  always_comb begin
    rd = '0;
    case (req_addr)
      A_PROT: rd = 32'(prot_q);
      A_IACT: rd = (32'(irq_v) << 31) | (32'(irq_pr) << 8) | 32'(irq_ln);
      A_FACT: rd = (32'(fiq_v) << 31) | (32'(fiq_pr) << 8) | 32'(fiq_ln);
      A_MASK: rd = 32'(mask_q);
      A_SSET: rd = 32'(swi_q);
      default: if (lvl_hit) rd = 32'(lvl_fiq[lvl_idx]) | (32'(lvl_pri[lvl_idx]) << 2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_err <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= blocked;
      rsp_rdata <= (req_valid && !req_write && !blocked) ? rd : '0;
    end
  end

  assert_hold_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack_irq |=> irq_o && $stable(irq_ln) && $stable(irq_pr));
  assert_hold_fiq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o && !ack_fiq |=> fiq_o && $stable(fiq_ln));
  assert_irq_winner_competed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> |($past(irq_cand) & (NLINES'(1) << irq_ln)));
  assert_fiq_winner_competed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> |($past(fiq_cand) & (NLINES'(1) << fiq_ln)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !irq_o);
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr && req_addr == A_MSET |=> &(mask_q | ~$past(req_wdata[NLINES-1:0])));
  assert_refused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(mask_q) && $stable(swi_q) && $stable(prot_q) && $stable(lvl_fiq));
  assert_refused_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, irq_o, fiq_o;
  logic [31:0] rsp_rdata;

  int tests = 0, fails = 0;
  logic [31:0] m_mask, m_swi;
  bit          m_fiq [32];
  int          m_pri [32];

  always #4 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit priv, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] rdata, output bit err);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_priv = priv; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (rsp_valid !== 1'b1) begin tests++; fails++; $display("FAIL R10: actual no response expected response"); end
    rdata = rsp_rdata; err = rsp_err;
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; bit e;
    bus(1'b1, 1'b1, a, d, r, e);
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] r);
    bit e;
    bus(1'b0, 1'b1, a, 32'h0, r, e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_act(input bit want_fiq, input logic [31:0] hw);
    logic [31:0] en;
    bit hit;
    int bl, bp;
    en = (hw | m_swi) & ~m_mask;
    hit = 0; bl = 0; bp = 0;
    for (int n = 0; n < 32; n++)
      if (en[n] && m_fiq[n] == want_fiq && (!hit || m_pri[n] < bp)) begin
        hit = 1; bl = n; bp = m_pri[n];
      end
    return hit ? (32'h8000_0000 | 32'(bp << 8) | 32'(bl)) : 32'h0;
  endfunction

  task automatic set_lvl(input int n, input bit f, input int p);
    m_fiq[n] = f; m_pri[n] = p;
    wr32(12'h100 + 12'(4 * n), 32'hFFFF_FF00 | 32'(p << 2) | 32'h2 | 32'(f));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, hw;
    bit e;
    void'($urandom(32'd1234));
    m_mask = '1; m_swi = '0;
    for (int n = 0; n < 32; n++) begin m_fiq[n] = 0; m_pri[n] = 0; end
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    chk("R1 irq_o", 32'(irq_o), 0); chk("R1 fiq_o", 32'(fiq_o), 0);
    rd32(12'h010, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd32(12'h01C, r); chk("R1 swi", r, 0);
    rd32(12'h114, r); chk("R1 level", r, 0);
    rd32(12'h004, r); chk("R1 prot", r, 0);
    rd32(12'h008, r); chk("R1 irq active", r, 0);
    rd32(12'h00C, r); chk("R1 fiq active", r, 0);

    wr32(12'h014, 32'h0000_FF00);
    wr32(12'h018, 32'h0000_0100);
    rd32(12'h010, r); chk("R2 set/clear aliases", r, 32'hFFFF_01FF);
    wr32(12'h010, 32'h0);
    rd32(12'h010, r); chk("R2 mask read-only", r, 32'hFFFF_01FF);
    wr32(12'h018, 32'hFFFF_FFFF);

    wr32(12'h01C, 32'h0000_00F0);
    wr32(12'h020, 32'h0000_0030);
    rd32(12'h01C, r); chk("R3 swi set/clear", r, 32'h0000_00C0);
    wr32(12'h020, 32'hFFFF_FFFF);

    set_lvl(9, 1, 37);
    rd32(12'h124, r); chk("R5 level fields", r, 32'h0000_0095);

    rd32(12'h040, r); chk("R10 unmapped read", r, 0);

    for (int it = 0; it < 40; it++) begin
      wr32(12'h018, 32'hFFFF_FFFF); m_mask = '1;
      wr32(12'h020, 32'hFFFF_FFFF); m_swi = '0;
      irq_lines = '0;
      wr32(12'h000, 32'h3);
      wait_cyc(2);
      chk("R8 released idle irq", 32'(irq_o), 0);
      chk("R8 released idle fiq", 32'(fiq_o), 0);
      for (int n = 0; n < 32; n++)
        set_lvl(n, bit'($urandom % 2), (it % 4 == 3) ? int'($urandom % 64) : int'($urandom % 4));
      hw = $urandom & $urandom;
      irq_lines = hw;
      r = $urandom & $urandom & $urandom;
      wr32(12'h01C, r); m_swi = r;
      r = (it % 5 == 0) ? 32'h0 : $urandom;
      wr32(12'h014, r); m_mask = m_mask & ~r;
      wait_cyc(2);
      chk("R4 R6 irq_o", 32'(irq_o), 32'(exp_act(0, hw) >> 31));
      chk("R4 R6 fiq_o", 32'(fiq_o), 32'(exp_act(1, hw) >> 31));
      rd32(12'h008, r); chk("R6 R7 irq winner", r, exp_act(0, hw));
      rd32(12'h00C, r); chk("R6 R7 fiq winner", r, exp_act(1, hw));
    end

    // tie and hold
    wr32(12'h018, 32'hFFFF_FFFF); m_mask = '1;
    wr32(12'h020, 32'hFFFF_FFFF); m_swi = '0;
    irq_lines = '0;
    wr32(12'h000, 32'h3);
    set_lvl(3, 0, 5); set_lvl(7, 0, 2); set_lvl(12, 0, 2);
    wr32(12'h01C, 32'h0000_0088);
    irq_lines = 32'h0000_1000;
    wr32(12'h014, 32'h0000_1088);
    wait_cyc(2);
    rd32(12'h008, r); chk("R6 tie lowest line", r, 32'h8000_0207);
    irq_lines = '0;
    wr32(12'h018, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R7 hold after masking", 32'(irq_o), 1);
    rd32(12'h008, r); chk("R7 active frozen", r, 32'h8000_0207);
    wr32(12'h014, 32'h0000_0008);
    wr32(12'h020, 32'h0000_0080);
    wr32(12'h000, 32'h1);
    wait_cyc(2);
    rd32(12'h008, r); chk("R8 next winner after release", r, 32'h8000_0503);
    wr32(12'h000, 32'h2);
    wait_cyc(2);
    chk("R8 fiq release leaves irq", 32'(irq_o), 1);

    // protection
    wr32(12'h018, 32'hFFFF_FFFF);
    bus(1'b1, 1'b0, 12'h004, 32'h1, r, e);
    chk("R9 prot needs priv err", 32'(e), 1);
    rd32(12'h004, r); chk("R9 prot unchanged", r, 0);
    bus(1'b0, 1'b0, 12'h010, 32'h0, r, e);
    chk("R9 unprotected read err", 32'(e), 0);
    chk("R9 unprotected read data", r, 32'hFFFF_FFFF);
    wr32(12'h004, 32'h1);
    bus(1'b1, 1'b0, 12'h014, 32'hFFFF_FFFF, r, e);
    chk("R9 refused write err", 32'(e), 1);
    rd32(12'h010, r); chk("R9 mask untouched", r, 32'hFFFF_FFFF);
    bus(1'b0, 1'b0, 12'h010, 32'h0, r, e);
    chk("R9 refused read err", 32'(e), 1);
    chk("R9 refused read zero", r, 0);
    wr32(12'h004, 32'h0);
    bus(1'b1, 1'b0, 12'h014, 32'h0000_0001, r, e);
    chk("R9 unprotected write err", 32'(e), 0);
    chk("R10 write returns zero", r, 0);
    rd32(12'h010, r); chk("R9 unprotected write lands", r, 32'hFFFF_FFFE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule